// File: doc/BRIEF.md
# Narrowing FIFO Read Port

This block is the read side of a synchronous FIFO whose storage holds 36-bit words. It takes the word at the head of storage, together with a not-empty level that comes from the write clock domain, and hands it to an output port that runs in one of three widths. In word mode a read takes the whole word. In half-word mode a read takes 18 bits, so each stored word is drained in two reads. In byte mode a read takes 9 bits, so each stored word is drained in four reads. An endian select chooses the order in which the pieces leave.

The port has two timing modes. In first-word-fall-through mode, the next piece already sits on the output and a ready flag says that it is valid. A read consumes that piece. In standard mode, a read loads the next piece into an output register on the clock edge, and the same flag means that storage still holds data. Width, endian order and timing mode are captured while reset is held, and the block ignores those pins afterwards.

Inside the block, the not-empty level passes through a synchronizer. A one-word buffer holds the word being unpacked, and a piece counter steps through its lanes. The block pops storage only when the buffer is empty or when the last piece of the word is read.

Top module: `fnr_rd`

## Requirements
- R1: A stored word consists of four 9-bit lanes: A on bits 35..27, B on 26..18, C on 17..9 and D on 8..0. In word mode (cfg_mode = 0, and also the unused code 3), each read returns all 36 bits on dout.
- R2: In half-word mode (cfg_mode = 1), each read drives dout[17:0] and the remaining bits are don't-care. With big-endian order (cfg_little = 0), the first read returns {A,B} and the second returns {C,D}. With little-endian order (cfg_little = 1), the first read returns {C,D} and the second returns {A,B}.
- R3: In byte mode (cfg_mode = 2), each read drives dout[8:0] and the remaining bits are don't-care. Big-endian order is A, B, C, D. Little-endian order is D, C, B, A.
- R4: The block captures cfg_mode, cfg_little and cfg_fwft (1 = first-word-fall-through) while rst_n is low. Changing these pins after reset has no effect on the piece order or the timing mode.
- R5: A read is accepted on a rising clk only when rd_csn = 0, rd_rnw = 1, rd_en = 1 and rdy = 1. In any other cycle, no piece is consumed and dout keeps its value.
- R6: Suppose storage is empty and st_avail rises just after a clock edge. Then rdy goes high after the third following rising edge. In first-word-fall-through mode, the first piece of the word is on dout at that same point.
- R7: rdy stays high after a read of any piece that is not the last piece of its word. rdy goes low after the read that takes the last piece of the final stored word.
- R8: In standard mode, dout changes only on an accepted read, and after that edge it shows the piece that the read took.
- R9: st_pop never asserts while storage is empty. Each stored word is popped exactly once, in storage order, and once a word has been popped, rdy is high on the next cycle.
- R10: After reset, rdy and st_pop are low, and the piece counter starts at the first piece.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Read clock |
| rst_n | input | 1 | Active-low synchronous reset; configuration is captured while it is low |
| cfg_mode | input | 2 | Port width: 0 word, 1 half-word, 2 byte, 3 treated as word |
| cfg_little | input | 1 | 1 selects little-endian piece order |
| cfg_fwft | input | 1 | 1 selects first-word-fall-through, 0 selects standard timing |
| st_avail | input | 1 | Storage not-empty level from the write clock domain |
| st_data | input | 36 | Word at the head of storage |
| st_pop | output | 1 | Removes the head word from storage on this edge |
| rd_csn | input | 1 | Active-low port select |
| rd_rnw | input | 1 | 1 selects a read cycle |
| rd_en | input | 1 | Read enable |
| dout | output | 36 | Output data; only the low bits used by the current width are meaningful |
| rdy | output | 1 | Output ready (first-word-fall-through) or not-empty (standard) |

## Verification
The bench builds the block with its default parameters: 9-bit lanes, which give 36-bit words, and a two-stage synchronizer, which gives the three-edge fall-through latency that R6 checks cycle by cycle. It resets the block twelve times, once for every combination of width, endian order and timing mode. After each reset it flips the configuration pins, so a block that keeps sampling them produces pieces in the wrong order. Each scenario measures the latency, then streams random words with select, direction and enable toggled at random, then drains storage completely. These phases exercise the mask that follows a pop, stalls between words, and the ready flag dropping on the final piece.

// File: rtl/fnr_pkg.sv
package fnr_pkg;

    localparam int LANES = 4;

    typedef enum logic [1:0] {
        BUS_WORD = 2'd0,
        BUS_HALF = 2'd1,
        BUS_BYTE = 2'd2,
        BUS_RSVD = 2'd3
    } bus_mode_e;

    // index of the final piece of a word for each port width
    function automatic logic [1:0] last_piece(bus_mode_e m);
        case (m)
            BUS_HALF: return 2'd1;
            BUS_BYTE: return 2'd3;
            default:  return 2'd0;
        endcase
    endfunction

endpackage

// File: rtl/fnr_sync.sv
module fnr_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], d};
    end

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/fnr_unpack.sv
module fnr_unpack
    import fnr_pkg::*;
#(
    parameter int LANE_W = 9,
    localparam int WORD_W = LANES * LANE_W
) (
    input  logic [WORD_W-1:0] word,
    input  bus_mode_e         mode,
    input  logic              little,
    input  logic [1:0]        idx,
    output logic [WORD_W-1:0] piece
);
    logic [LANE_W-1:0] lane [LANES];
    logic [1:0]        bsel;
    logic              hsel;

    // lane 3 is the most significant lane (A), lane 0 the least (D)
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane[g] = word[g*LANE_W +: LANE_W];
    end

    assign bsel = little ? idx : (2'd3 - idx);
    assign hsel = little ? idx[0] : ~idx[0];

    always_comb begin
        piece = '0;
        case (mode)
            BUS_HALF: piece[2*LANE_W-1:0] = {lane[{hsel, 1'b1}], lane[{hsel, 1'b0}]};
            BUS_BYTE: piece[LANE_W-1:0]   = lane[bsel];
            default:  piece               = word;
        endcase
    end
endmodule

// File: rtl/fnr_rd.sv
module fnr_rd
    import fnr_pkg::*;
#(
    parameter int LANE_W      = 9,
    parameter int SYNC_STAGES = 2,
    localparam int WORD_W     = LANES * LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cfg_mode,
    input  logic              cfg_little,
    input  logic              cfg_fwft,
    input  logic              st_avail,
    input  logic [WORD_W-1:0] st_data,
    output logic              st_pop,
    input  logic              rd_csn,
    input  logic              rd_rnw,
    input  logic              rd_en,
    output logic [WORD_W-1:0] dout,
    output logic              rdy
);
    typedef struct packed {
        bus_mode_e              mode;
        logic                   little;
        logic                   fwft;
        logic [SYNC_STAGES-1:0] hold;
        logic [WORD_W-1:0]      word;
        logic                   full;
        logic [1:0]             idx;
        logic [WORD_W-1:0]      dq;
    } rd_state_t;

    rd_state_t         st_q, st_d;
    logic              pop;
    logic              rd_acc;
    logic              at_last;
    logic              avail_sync;
    logic              avail_ok;
    logic              fwft_q;
    logic [WORD_W-1:0] piece;

    fnr_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (st_avail),
        .q     (avail_sync)
    );

    fnr_unpack #(.LANE_W(LANE_W)) u_unpack (
        .word   (st_q.word),
        .mode   (st_q.mode),
        .little (st_q.little),
        .idx    (st_q.idx),
        .piece  (piece)
    );

    // a synced not-empty level is stale for SYNC_STAGES cycles after a pop
    assign avail_ok = avail_sync & ~|st_q.hold;
    assign at_last  = (st_q.idx == last_piece(st_q.mode));
    assign rd_acc   = ~rd_csn & rd_rnw & rd_en & st_q.full;
    assign fwft_q   = st_q.fwft;

    always_comb begin
        st_d = st_q;
        pop  = 1'b0;
        if (rd_acc) begin
            if (!st_q.fwft) st_d.dq = piece;
            if (at_last) begin
                st_d.idx = '0;
                if (avail_ok) begin
                    pop       = 1'b1;
                    st_d.word = st_data;
                end else begin
                    st_d.full = 1'b0;
                end
            end else begin
                st_d.idx = st_q.idx + 2'd1;
            end
        end else if (!st_q.full && avail_ok) begin
            pop       = 1'b1;
            st_d.word = st_data;
            st_d.full = 1'b1;
            st_d.idx  = '0;
        end
        st_d.hold = {st_q.hold[SYNC_STAGES-2:0], pop};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q        <= '0;
            st_q.mode   <= bus_mode_e'(cfg_mode);
            st_q.little <= cfg_little;
            st_q.fwft   <= cfg_fwft;
        end else begin
            st_q <= st_d;
        end
    end

    assign dout   = st_q.fwft ? piece : st_q.dq;
    assign rdy    = st_q.full;
    assign st_pop = pop;
endmodule

// File: rtl/fnr_rd_chk.sv
module fnr_rd_chk #(
    parameter int WORD_W = 36
) (
    input logic              clk,
    input logic              rst_n,
    input logic              st_pop,
    input logic              rd_csn,
    input logic              rd_rnw,
    input logic              rd_en,
    input logic [WORD_W-1:0] dout,
    input logic              rdy,
    input logic              fwft_q,
    input logic              at_last
);
    logic acc;
    assign acc = ~rd_csn & rd_rnw & rd_en & rdy;

    // R5: fall-through output and flag hold while no read is accepted
    a_r5_fwft_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (fwft_q && rdy && !acc) |=> ($stable(dout) && rdy));

    // R8: standard-mode output register moves only on an accepted read
    a_r8_std_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!fwft_q && !acc) |=> $stable(dout));

    // R7: ready survives the read of a piece that is not the last of its word
    a_r7_mid_word: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && !at_last) |=> rdy);

    // R9: a popped word is presented as ready on the next cycle
    a_r9_pop_ready: assert property (@(posedge clk) disable iff (!rst_n)
        st_pop |=> rdy);

    // R9: no back-to-back pop while the synced level is still stale
    a_r9_pop_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        st_pop |=> !st_pop);
endmodule

bind fnr_rd fnr_rd_chk #(.WORD_W(WORD_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .st_pop  (st_pop),
    .rd_csn  (rd_csn),
    .rd_rnw  (rd_rnw),
    .rd_en   (rd_en),
    .dout    (dout),
    .rdy     (rdy),
    .fwft_q  (fwft_q),
    .at_last (at_last)
);

// File: tb/fnr_rd_bench.sv
`timescale 1ns/1ps
module fnr_rd_bench;
    localparam int WW = 36;

    typedef struct {
        logic [WW-1:0] v;
        bit            last;
    } piece_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    cfg_mode = '0;
    logic          cfg_little = 1'b0;
    logic          cfg_fwft = 1'b0;
    logic          st_avail = 1'b0;
    logic [WW-1:0] st_data = '0;
    logic          st_pop;
    logic          rd_csn = 1'b1;
    logic          rd_rnw = 1'b0;
    logic          rd_en = 1'b0;
    logic [WW-1:0] dout;
    logic          rdy;

    int checks = 0;
    int failures = 0;

    logic [WW-1:0] stq[$];
    piece_t        expq[$];
    bit [1:0]      m_mode;
    bit            m_little;
    bit            m_fwft;

    bit            have_prev;
    bit            p_acc, p_rdy, p_last;
    logic [WW-1:0] p_dout, p_piece;

    always #2.5 clk = ~clk;

    fnr_rd u_fnr_rd (
        .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_little(cfg_little),
        .cfg_fwft(cfg_fwft), .st_avail(st_avail), .st_data(st_data), .st_pop(st_pop),
        .rd_csn(rd_csn), .rd_rnw(rd_rnw), .rd_en(rd_en), .dout(dout), .rdy(rdy)
    );

    task automatic chk(input bit ok, input string tag, input logic [WW-1:0] act,
                       input logic [WW-1:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h mode=%0d little=%0d fwft=%0d",
                     tag, act, exp, m_mode, m_little, m_fwft);
        end
    endtask

    function automatic logic [WW-1:0] mask_of();
        case (m_mode)
            2'd1:    return 36'h0_0003_FFFF;
            2'd2:    return 36'h0_0000_01FF;
            default: return {WW{1'b1}};
        endcase
    endfunction

    function automatic string data_tag();
        string base;
        case (m_mode)
            2'd1:    base = "R2";
            2'd2:    base = "R3";
            default: base = "R1";
        endcase
        return m_fwft ? {base, "/R4"} : {base, "/R4/R8"};
    endfunction

    // expected pieces written from R1..R3
    task automatic push_word(input logic [WW-1:0] w);
        logic [8:0] a, b, c, d;
        a = w[35:27]; b = w[26:18]; c = w[17:9]; d = w[8:0];
        stq.push_back(w);
        case (m_mode)
            2'd1: begin
                if (!m_little) begin
                    expq.push_back('{{18'd0, a, b}, 1'b0});
                    expq.push_back('{{18'd0, c, d}, 1'b1});
                end else begin
                    expq.push_back('{{18'd0, c, d}, 1'b0});
                    expq.push_back('{{18'd0, a, b}, 1'b1});
                end
            end
            2'd2: begin
                if (!m_little) begin
                    expq.push_back('{{27'd0, a}, 1'b0});
                    expq.push_back('{{27'd0, b}, 1'b0});
                    expq.push_back('{{27'd0, c}, 1'b0});
                    expq.push_back('{{27'd0, d}, 1'b1});
                end else begin
                    expq.push_back('{{27'd0, d}, 1'b0});
                    expq.push_back('{{27'd0, c}, 1'b0});
                    expq.push_back('{{27'd0, b}, 1'b0});
                    expq.push_back('{{27'd0, a}, 1'b1});
                end
            end
            default: expq.push_back('{w, 1'b1});
        endcase
    endtask

    // one read-clock cycle of stimulus and comparison
    task automatic step(input bit wr, input logic [WW-1:0] wd,
                        input bit csn, input bit rnw, input bit en);
        bit acc, popped;
        logic [WW-1:0] mk;
        piece_t pc;
        @(negedge clk);
        rd_csn = csn; rd_rnw = rnw; rd_en = en;
        #1;
        mk  = mask_of();
        acc = !csn && rnw && en && rdy;
        if (have_prev) begin
            if (!m_fwft) begin
                if (p_acc) chk((dout & mk) == (p_piece & mk), data_tag(), dout & mk, p_piece & mk);
                else       chk(dout == p_dout, "R5/R8 std output held", dout, p_dout);
            end else if (p_rdy && !p_acc && rdy) begin
                chk(dout == p_dout, "R5 fwft output held", dout, p_dout);
            end
            if (p_acc && !p_last) chk(rdy, "R7 ready after mid-word piece", rdy, 1);
        end
        chk(!(rdy && expq.size() == 0), "R7 ready with nothing stored", rdy, 0);
        if (st_pop) chk(stq.size() > 0, "R9 pop of empty storage", st_pop, 0);
        if (acc) begin
            pc = expq.pop_front();
            if (m_fwft) chk((dout & mk) == (pc.v & mk), data_tag(), dout & mk, pc.v & mk);
            p_piece = pc.v;
            p_last  = pc.last;
        end
        p_acc = acc; p_rdy = rdy; p_dout = dout; have_prev = 1'b1;
        popped = st_pop;
        @(posedge clk);
        #1;
        if (popped && stq.size() > 0) void'(stq.pop_front());
        if (wr) push_word(wd);
        st_avail = (stq.size() > 0);
        st_data  = (stq.size() > 0) ? stq[0] : '0;
    endtask

    task automatic do_reset(input bit [1:0] mode, input bit little, input bit fwft);
        @(negedge clk);
        rst_n = 1'b0;
        cfg_mode = mode; cfg_little = little; cfg_fwft = fwft;
        m_mode = mode; m_little = little; m_fwft = fwft;
        stq.delete(); expq.delete();
        st_avail = 1'b0; st_data = '0;
        rd_csn = 1'b1; rd_rnw = 1'b0; rd_en = 1'b0;
        have_prev = 1'b0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R4: configuration pins move after reset and must be ignored
        cfg_mode = ~mode; cfg_little = ~little; cfg_fwft = ~fwft;
        #1;
        chk(rdy == 1'b0, "R10 ready low after reset", rdy, 0);
        chk(st_pop == 1'b0, "R10 no pop after reset", st_pop, 0);
    endtask

    task automatic run_cfg(input bit [1:0] mode, input bit little, input bit fwft);
        logic [WW-1:0] w;
        do_reset(mode, little, fwft);
        // R6: latency from first write into empty storage
        w = {$urandom(), $urandom()};
        step(1'b1, w, 1'b1, 1'b0, 1'b0);
        chk(!rdy, "R6 ready too early (edge 0)", rdy, 0);
        step(1'b0, '0, 1'b1, 1'b0, 1'b0);
        chk(!rdy, "R6 ready too early (edge 1)", rdy, 0);
        step(1'b0, '0, 1'b1, 1'b0, 1'b0);
        chk(!rdy, "R6 ready too early (edge 2)", rdy, 0);
        step(1'b0, '0, 1'b1, 1'b0, 1'b0);
        chk(rdy, "R6 ready after third edge", rdy, 1);
        if (fwft && expq.size() > 0)
            chk((dout & mask_of()) == (expq[0].v & mask_of()), "R6 first piece falls through",
                dout & mask_of(), expq[0].v & mask_of());
        // random traffic
        for (int i = 0; i < 300; i++) begin
            bit wr;
            wr = ($urandom_range(2) == 0) && (stq.size() < 8);
            w  = {$urandom(), $urandom()};
            step(wr, w, $urandom_range(7) == 0, $urandom_range(7) != 0, $urandom_range(3) != 0);
        end
        // drain
        for (int i = 0; i < 400 && expq.size() > 0; i++) step(1'b0, '0, 1'b0, 1'b1, 1'b1);
        repeat (4) step(1'b0, '0, 1'b0, 1'b1, 1'b1);
        chk(!rdy, "R7 ready low after final piece", rdy, 0);
        chk(stq.size() == 0 && expq.size() == 0, "R9 every word consumed once",
            stq.size(), 0);
    endtask

    initial begin
        for (int m = 0; m < 3; m++)
            for (int l = 0; l < 2; l++)
                for (int f = 0; f < 2; f++)
                    run_cfg(2'(m), l[0], f[0]);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        checks++;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule